// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard unit of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). The pipeline runs a small integer set: logical and/or, add, sub, mul, add-immediate, word load and store, branch-on-equal and an unconditional jump. The block reads register indices, write enables and load flags from the pipeline registers that lie between the stages. It also reads the source-use flags and the transfer class of the instruction in decode. From these it steers the operand multiplexers in front of the ALU and in front of the equality comparator, which sits in decode. It also decides when the front of the pipeline must hold.

Two kinds of hold exist. The first is a data hold: an instruction needs a value that no forwarding path can yet deliver. This happens with a load followed directly by a consumer, or with a branch whose operand is still being computed in execute or loaded in memory. During a hold the program counter and the fetch/decode register keep their contents, and an empty slot enters the decode/execute register. The second is the control-transfer slot. Once a branch or jump leaves decode, the instruction fetched sequentially behind it is void for exactly one cycle. In that cycle the block inserts a bubble, ignores the void instruction's register fields, and lets fetch continue from the resolved address.

Top module: `hz_ctrl`

## Requirements
- R1: `fwd_a` / `fwd_b` equal 1 (take the execute/memory result) when `mem_regwr` is set, `mem_rd` is nonzero and `mem_rd` equals `ex_rs` / `ex_rt`.
- R2: When the memory and writeback stages both write the matching register, the memory stage wins (code 1). Code 2 (writeback result) is given only when `wb_regwr` is set, `wb_rd` is nonzero and matches, and the memory stage does not match.
- R3: Register 0 never causes forwarding or a hold; with no match every select is 0 (register file).
- R4: A load in execute (`ex_memrd` and `ex_regwr`, nonzero `ex_rd`) whose destination equals a used decode source holds for one cycle: `pc_we`=0, `ifid_we`=0, `idex_bubble`=1. The hold clears as soon as the load has left execute.
- R5: `br_fwd_a` / `br_fwd_b` for the decode-stage sources `id_rs` / `id_rt` give code 1 from a matching non-load in the memory stage, else code 2 from a matching writeback, else 0.
- R6: A branch in decode (`id_cls`=1) holds when one of its used sources matches a nonzero `ex_rd` with `ex_regwr` set, or a nonzero `mem_rd` of a load in memory (`mem_memrd` with `mem_regwr`).
- R7: In the cycle after a branch (`id_cls`=1) or jump (`id_cls`=2) leaves decode without a hold, `idex_bubble`=1 while `pc_we` and `ifid_we` stay 1, whatever the decode fields show.
- R8: While `rst_n` is low and in the first cycle after it rises, there is no transfer slot: with no hazard, `idex_bubble`=0 and `pc_we`=1.
- R9: A decode source whose use flag (`id_use_rs`, `id_use_rt`) is clear never causes a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs | input | 5 | First source index in decode |
| id_rt | input | 5 | Second source index in decode |
| id_use_rs | input | 1 | Decode instruction reads `id_rs` |
| id_use_rt | input | 1 | Decode instruction reads `id_rt` |
| id_cls | input | 2 | Decode transfer class: 0 other, 1 branch, 2 jump, 3 treated as other |
| ex_rs | input | 5 | First source index in execute |
| ex_rt | input | 5 | Second source index in execute |
| ex_rd | input | 5 | Destination index in execute |
| ex_regwr | input | 1 | Execute instruction writes a register |
| ex_memrd | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination index in memory stage |
| mem_regwr | input | 1 | Memory-stage instruction writes a register |
| mem_memrd | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination index in writeback |
| wb_regwr | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | ALU operand A source: 0 file, 1 exec/mem, 2 mem/wb |
| fwd_b | output | 2 | ALU operand B source, same coding |
| br_fwd_a | output | 2 | Comparator operand A source, same coding |
| br_fwd_b | output | 2 | Comparator operand B source, same coding |
| pc_we | output | 1 | Program counter load enable |
| ifid_we | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Zero the control fields entering decode/execute |

## Verification
Directed patterns set one producer against one consumer at a time. A single memory-stage match, a double match, a writeback-only match and a register-0 match tell the forwarding priority apart from the default path. Load-then-use, load-with-unused-source and branch-behind-producer patterns separate the two hold causes from the cases that must not hold. A jump followed by a hazardous-looking void slot shows that the transfer slot masks decode. A long run of random stage contents drawn from a few register indices then gives frequent collisions, and every output is compared each cycle with a behavioural model.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } src_sel_e;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_BEQ   = 2'd1,
    CLS_JMP   = 2'd2,
    CLS_RSVD  = 2'd3
  } id_cls_e;
endpackage

// File: rtl/hz_src_pick.sv
module hz_src_pick #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] near_rd,
  input  logic          near_ok,
  input  logic [AW-1:0] far_rd,
  input  logic          far_ok,
  output logic [1:0]    sel
);
  import hz_pkg::*;

  logic src_live;
  logic near_hit;
  logic far_hit;

  always_comb begin
    src_live = (src != '0);
    near_hit = src_live && near_ok && (near_rd == src);
    far_hit  = src_live && far_ok && (far_rd == src);
    if (near_hit) begin
      sel = SRC_EXMEM;
    end else if (far_hit) begin
      sel = SRC_MEMWB;
    end else begin
      sel = SRC_RF;
    end
  end
endmodule

// File: rtl/hz_hold_detect.sv
module hz_hold_detect #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic          id_is_beq,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_regwr,
  input  logic          ex_memrd,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_regwr,
  input  logic          mem_memrd,
  output logic          hold
);
  logic ex_dst_live;
  logic mem_load_live;
  logic ex_hits_src;
  logic mem_hits_src;
  logic load_use;
  logic beq_wait;

  always_comb begin
    ex_dst_live   = ex_regwr && (ex_rd != '0);
    mem_load_live = mem_memrd && mem_regwr && (mem_rd != '0);
    ex_hits_src   = (id_use_rs && (ex_rd == id_rs)) ||
                    (id_use_rt && (ex_rd == id_rt));
    mem_hits_src  = (id_use_rs && (mem_rd == id_rs)) ||
                    (id_use_rt && (mem_rd == id_rt));
    load_use      = ex_dst_live && ex_memrd && ex_hits_src;
    beq_wait      = id_is_beq &&
                    ((ex_dst_live && ex_hits_src) || (mem_load_live && mem_hits_src));
    hold          = load_use || beq_wait;
  end
endmodule

// File: rtl/hz_slot_track.sv
module hz_slot_track (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_leaves,
  output logic void_slot
);
  logic slot_d;
  logic slot_q;

  always_comb begin
    slot_d = xfer_leaves;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
    end
  end

  assign void_slot = slot_q;
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
  parameter int AW = hz_pkg::REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic [1:0]    id_cls,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_regwr,
  input  logic          ex_memrd,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_regwr,
  input  logic          mem_memrd,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_regwr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic [1:0]    br_fwd_a,
  output logic [1:0]    br_fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble
);
  import hz_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] alu_src;
  logic [NSRC-1:0][AW-1:0] cmp_src;
  logic [NSRC-1:0][1:0]    alu_sel;
  logic [NSRC-1:0][1:0]    cmp_sel;
  logic                    cmp_near_ok;
  logic                    raw_hold;
  logic                    void_slot;
  logic                    is_beq;
  logic                    is_xfer;
  logic                    hold;
  logic                    xfer_leaves;

  assign alu_src     = {ex_rt, ex_rs};
  assign cmp_src     = {id_rt, id_rs};
  assign cmp_near_ok = mem_regwr && !mem_memrd;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_pick #(.AW(AW)) u_alu_pick (
      .src     (alu_src[g]),
      .near_rd (mem_rd),
      .near_ok (mem_regwr),
      .far_rd  (wb_rd),
      .far_ok  (wb_regwr),
      .sel     (alu_sel[g])
    );
    hz_src_pick #(.AW(AW)) u_cmp_pick (
      .src     (cmp_src[g]),
      .near_rd (mem_rd),
      .near_ok (cmp_near_ok),
      .far_rd  (wb_rd),
      .far_ok  (wb_regwr),
      .sel     (cmp_sel[g])
    );
  end

  always_comb begin
    is_beq  = (id_cls == CLS_BEQ);
    is_xfer = (id_cls == CLS_BEQ) || (id_cls == CLS_JMP);
  end

  hz_hold_detect #(.AW(AW)) u_hold (
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .id_use_rs (id_use_rs),
    .id_use_rt (id_use_rt),
    .id_is_beq (is_beq),
    .ex_rd     (ex_rd),
    .ex_regwr  (ex_regwr),
    .ex_memrd  (ex_memrd),
    .mem_rd    (mem_rd),
    .mem_regwr (mem_regwr),
    .mem_memrd (mem_memrd),
    .hold      (raw_hold)
  );

  always_comb begin
    hold        = raw_hold && !void_slot;
    xfer_leaves = is_xfer && !hold && !void_slot;
  end

  hz_slot_track u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_leaves (xfer_leaves),
    .void_slot   (void_slot)
  );

  always_comb begin
    fwd_a       = alu_sel[0];
    fwd_b       = alu_sel[1];
    br_fwd_a    = cmp_sel[0];
    br_fwd_b    = cmp_sel[1];
    pc_we       = !hold;
    ifid_we     = !hold;
    idex_bubble = hold || void_slot;
  end
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_rs,
  input logic          id_use_rs,
  input logic [1:0]    id_cls,
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rd,
  input logic          ex_regwr,
  input logic          ex_memrd,
  input logic [AW-1:0] mem_rd,
  input logic          mem_regwr,
  input logic [AW-1:0] wb_rd,
  input logic          wb_regwr,
  input logic [1:0]    fwd_a,
  input logic [1:0]    br_fwd_a,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          idex_bubble
);
  logic seen_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_clk <= 1'b0;
    end else begin
      seen_clk <= 1'b1;
    end
  end

  p_near_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_regwr && mem_rd != '0 && mem_rd == ex_rs) |-> fwd_a == 2'd1);

  p_far_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_regwr && wb_rd != '0 && wb_rd == ex_rs && !(mem_regwr && mem_rd == ex_rs))
      |-> fwd_a == 2'd2);

  p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs == '0) |-> (fwd_a == 2'd0));

  p_hold_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |-> (!ifid_we && idex_bubble));

  p_load_use_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_memrd && ex_regwr && ex_rd != '0 && id_use_rs && ex_rd == id_rs && !idex_bubble)
      |-> 1'b0);

  p_cmp_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0) |-> (br_fwd_a == 2'd0));

  p_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && pc_we && !idex_bubble && (id_cls == 2'd1 || id_cls == 2'd2))
      |=> (idex_bubble && pc_we && ifid_we));

  p_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we == ifid_we);
endmodule

bind hz_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .id_rs       (id_rs),
  .id_use_rs   (id_use_rs),
  .id_cls      (id_cls),
  .ex_rs       (ex_rs),
  .ex_rd       (ex_rd),
  .ex_regwr    (ex_regwr),
  .ex_memrd    (ex_memrd),
  .mem_rd      (mem_rd),
  .mem_regwr   (mem_regwr),
  .wb_rd       (wb_rd),
  .wb_regwr    (wb_regwr),
  .fwd_a       (fwd_a),
  .br_fwd_a    (br_fwd_a),
  .pc_we       (pc_we),
  .ifid_we     (ifid_we),
  .idex_bubble (idex_bubble)
);

// File: tb/hz_ctrl_tb.sv
module hz_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 400;

  logic       clk;
  logic       rst_n;
  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic       id_use_rs, id_use_rt, ex_regwr, ex_memrd, mem_regwr, mem_memrd, wb_regwr;
  logic [1:0] id_cls;
  logic [1:0] fwd_a, fwd_b, br_fwd_a, br_fwd_b;
  logic       pc_we, ifid_we, idex_bubble;

  int checks = 0;
  int errors = 0;
  bit m_void = 0;
  bit done = 0;

  hz_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
    .id_cls(id_cls), .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
    .ex_regwr(ex_regwr), .ex_memrd(ex_memrd), .mem_rd(mem_rd),
    .mem_regwr(mem_regwr), .mem_memrd(mem_memrd), .wb_rd(wb_rd), .wb_regwr(wb_regwr),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: priority pick of a producer for one source index
  function automatic int m_pick(int src, int n_rd, bit n_ok, int f_rd, bit f_ok);
    if (src == 0) return 0;
    if (n_ok && n_rd == src) return 1;
    if (f_ok && f_rd == src) return 2;
    return 0;
  endfunction

  function automatic bit m_uses(int rd);
    return (id_use_rs && rd == id_rs) || (id_use_rt && rd == id_rt);
  endfunction

  function automatic bit m_hold();
    bit lu, bw;
    if (m_void) return 0;
    lu = ex_memrd && ex_regwr && ex_rd != 0 && m_uses(ex_rd);
    bw = id_cls == 2'd1 &&
         ((ex_regwr && ex_rd != 0 && m_uses(ex_rd)) ||
          (mem_memrd && mem_regwr && mem_rd != 0 && m_uses(mem_rd)));
    return lu || bw;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_void <= 0;
    else m_void <= !m_void && !m_hold() && (id_cls == 2'd1 || id_cls == 2'd2);
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clr();
    id_rs = 0; id_rt = 0; id_use_rs = 0; id_use_rt = 0; id_cls = 0;
    ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_regwr = 0; ex_memrd = 0;
    mem_rd = 0; mem_regwr = 0; mem_memrd = 0; wb_rd = 0; wb_regwr = 0;
  endtask

  task automatic model_cmp();
    bit h;
    h = m_hold();
    chk("R1 fwd_a", fwd_a, m_pick(ex_rs, mem_rd, mem_regwr, wb_rd, wb_regwr));
    chk("R2 fwd_b", fwd_b, m_pick(ex_rt, mem_rd, mem_regwr, wb_rd, wb_regwr));
    chk("R5 br_fwd_a", br_fwd_a, m_pick(id_rs, mem_rd, mem_regwr && !mem_memrd, wb_rd, wb_regwr));
    chk("R5 br_fwd_b", br_fwd_b, m_pick(id_rt, mem_rd, mem_regwr && !mem_memrd, wb_rd, wb_regwr));
    chk("R4 pc_we", pc_we, !h);
    chk("R6 ifid_we", ifid_we, !h);
    chk("R7 idex_bubble", idex_bubble, h || m_void);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    clr();
    id_cls = 2'd1;
    #(CLK_PERIOD * 2 + 1);
    chk("R8 reset bubble", idex_bubble, 0);
    chk("R8 reset pc_we", pc_we, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 first cycle bubble", idex_bubble, 0);
    step(); clr(); #1;

    // R1: memory-stage producer
    ex_rs = 3; mem_rd = 3; mem_regwr = 1; #1;
    chk("R1 near fwd", fwd_a, 1);
    // R2: both match, memory stage wins; then writeback only
    wb_rd = 3; wb_regwr = 1; #1;
    chk("R2 priority", fwd_a, 1);
    mem_regwr = 0; ex_rt = 3; #1;
    chk("R2 far fwd a", fwd_a, 2);
    chk("R2 far fwd b", fwd_b, 2);
    // R3: register 0
    clr(); mem_regwr = 1; wb_regwr = 1; ex_regwr = 1; ex_memrd = 1;
    id_use_rs = 1; id_use_rt = 1; #1;
    chk("R3 zero fwd_a", fwd_a, 0);
    chk("R3 zero br", br_fwd_a, 0);
    chk("R3 zero no hold", pc_we, 1);

    // R4: load-use holds one cycle
    step(); clr();
    ex_rd = 5; ex_regwr = 1; ex_memrd = 1; id_rs = 5; id_use_rs = 1; #1;
    chk("R4 hold pc", pc_we, 0);
    chk("R4 hold ifid", ifid_we, 0);
    chk("R4 hold bubble", idex_bubble, 1);
    step(); ex_regwr = 0; ex_memrd = 0; ex_rd = 0; mem_rd = 5; mem_regwr = 1; mem_memrd = 1; #1;
    chk("R4 released", pc_we, 1);
    // R9: unused source
    step(); clr();
    ex_rd = 6; ex_regwr = 1; ex_memrd = 1; id_rt = 6; id_use_rt = 0; id_use_rs = 1; id_rs = 1; #1;
    chk("R9 unused rt", pc_we, 1);

    // R6: branch behind ALU producer in execute
    step(); clr();
    id_cls = 0; id_rs = 7; id_use_rs = 1; id_use_rt = 1; ex_rd = 7; ex_regwr = 1; #1;
    chk("R6 non-branch no hold", pc_we, 1);
    id_cls = 1; #1;
    chk("R6 beq waits ex", pc_we, 0);
    step(); ex_regwr = 0; mem_rd = 7; mem_regwr = 1; mem_memrd = 1; #1;
    chk("R6 beq waits load", pc_we, 0);
    step(); mem_memrd = 0; id_cls = 0; #1;
    chk("R5 cmp near fwd", br_fwd_a, 1);
    chk("R5 no hold", pc_we, 1);

    // R7: jump leaves decode, next slot void even with hazard pattern
    step(); clr(); id_cls = 2;
    step(); clr();
    ex_rd = 9; ex_regwr = 1; ex_memrd = 1; id_rs = 9; id_use_rs = 1; #1;
    chk("R7 void bubble", idex_bubble, 1);
    chk("R7 void pc_we", pc_we, 1);
    step(); #1;
    chk("R7 slot over", pc_we, 0);

    // Random run against the model
    for (int i = 0; i < RAND_CYCLES; i++) begin
      step();
      id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
      ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3));
      ex_rd = 5'($urandom_range(0, 3)); mem_rd = 5'($urandom_range(0, 3));
      wb_rd = 5'($urandom_range(0, 3)); id_cls = 2'($urandom_range(0, 3));
      id_use_rs = 1'($urandom); id_use_rt = 1'($urandom);
      ex_regwr = 1'($urandom); ex_memrd = 1'($urandom);
      mem_regwr = 1'($urandom); mem_memrd = 1'($urandom); wb_regwr = 1'($urandom);
      #1;
      model_cmp();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule